// File: doc/BRIEF.md
# Stage Execution Window Profiler

This block times how long each stage of a computation on an attached target takes. Target and profiler share one reference clock, so a cycle counter inside the block measures the target's progress with single-cycle resolution. The target flips one trigger line as it enters each stage, and every flip is an edge that marks a boundary. An arm pulse clears all results and restarts the counter from zero. Each trigger edge then stores the counter value twice: as the start of the stage being entered and as the end of the stage just left.

The last stage is closed in one of two ways. A done pulse from the target closes it. If no done pulse arrives, a quiet-line timeout closes it. A flag records which of the two applied. Results are read through an indexed port that returns a start and end pair for each stage. The windows are then used to confine the timing offset of an injected supply fault to a single stage.

Top module: `stage_window_profiler`

## Requirements
- R1: After reset, busy, finished, timed_out and overflow are 0, stage_count is 0, and every read returns valid 0 with start and end 0.
- R2: An arm pulse clears all entries, the stage index and every flag, sets busy and restarts the counter. An input seen at the Nth rising clock edge after the arm edge is stamped N-1.
- R3: Every trigger edge, rising or falling, opens the next stage with its stamp as start. The same stamp becomes the end of the previous stage, which then reads valid.
- R4: A done pulse while a stage is open closes it with the done stamp, sets finished and leaves timed_out at 0. A done pulse with no stage open finishes the run with no valid stage.
- R5: After TIMEOUT_CYC cycles with no recorded trigger edge and no done pulse, the open stage closes with end equal to its start plus TIMEOUT_CYC+1. Both finished and timed_out are set.
- R6: A trigger edge after all NUM_STAGES stages have opened sets a sticky overflow flag and records nothing. The last stage stays open and stage_count stays at NUM_STAGES.
- R7: The cycle counter holds at its all-ones value (2^CNT_W - 1) instead of wrapping, so late stamps read as that value.
- R8: A read of a stage that has not closed returns valid 0 with start and end 0. So does a read at an index of NUM_STAGES or above.
- R9: Once finished, trigger edges and done pulses are ignored until the next arm: stage_count, overflow and the stored ranges do not change.
- R10: When a done pulse and a trigger edge arrive together, the done pulse wins. The open stage closes at that stamp, and the edge neither opens a stage nor sets overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock shared with the target |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Clears results and starts a new run |
| trig_i | input | 1 | Stage trigger line; every edge marks a boundary |
| done_i | input | 1 | Target completion pulse |
| rd_idx_i | input | IDX_W | Stage index to read |
| rd_valid_o | output | 1 | Selected stage is closed |
| rd_start_o | output | CNT_W | Start stamp of the selected stage |
| rd_end_o | output | CNT_W | End stamp of the selected stage |
| busy_o | output | 1 | A run is in progress |
| finished_o | output | 1 | The run has closed |
| timed_out_o | output | 1 | The run was closed by the timeout |
| overflow_o | output | 1 | A trigger edge came after the last stage |
| stage_count_o | output | IDX_W | Number of stages opened |

## Verification
A wrong stage index appears at once on stage_count_o. On the next read it also shows up as a range stored at the wrong index, or as a missing valid bit. A counter that runs or stops at the wrong moment shifts every later stamp by a fixed amount, so the first stamp after the fault already differs from the count kept by the bench. A timeout or overflow decision made on the wrong cycle changes the closing stamp, or the flag, in the cycle the run ends.

// File: rtl/stage_window_profiler.sv
module stage_window_profiler #(
  parameter int NUM_STAGES  = 5,
  parameter int CNT_W       = 32,
  parameter int TIMEOUT_CYC = 1000000,
  localparam int IDX_W      = $clog2(NUM_STAGES + 1),
  localparam int IDLE_W     = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             trig_i,
  input  logic             done_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [CNT_W-1:0] rd_start_o,
  output logic [CNT_W-1:0] rd_end_o,
  output logic             busy_o,
  output logic             finished_o,
  output logic             timed_out_o,
  output logic             overflow_o,
  output logic [IDX_W-1:0] stage_count_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [IDX_W-1:0]  LAST    = IDX_W'(NUM_STAGES);
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(TIMEOUT_CYC);

  logic                  run_q, fin_q, tmo_q, ovf_q, trig_q;
  logic [IDX_W-1:0]      idx_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [IDLE_W-1:0]     idle_q;
  logic [CNT_W-1:0]      start_q [NUM_STAGES];
  logic [CNT_W-1:0]      end_q   [NUM_STAGES];
  logic [NUM_STAGES-1:0] val_q;

  wire              edge_w = run_q && (trig_i ^ trig_q);
  wire              open_w = run_q && (idx_q != '0);
  wire              rec_w  = edge_w && !done_i && (idx_q < LAST);
  wire              ovf_w  = edge_w && !done_i && (idx_q == LAST);
  wire              tmo_w  = open_w && !done_i && !rec_w && (idle_q >= IDLE_LIM);
  wire              fin_w  = run_q && (done_i || tmo_w);
  wire [IDX_W-1:0]  prev_w = idx_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
      tmo_q  <= 1'b0;
      ovf_q  <= 1'b0;
      trig_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      idle_q <= '0;
      val_q  <= '0;
      for (int i = 0; i < NUM_STAGES; i++) begin
        start_q[i] <= '0;
        end_q[i]   <= '0;
      end
    end else if (arm_i) begin
      run_q  <= 1'b1;
      fin_q  <= 1'b0;
      tmo_q  <= 1'b0;
      ovf_q  <= 1'b0;
      trig_q <= trig_i;
      idx_q  <= '0;
      cnt_q  <= '0;
      idle_q <= '0;
      val_q  <= '0;
      for (int i = 0; i < NUM_STAGES; i++) begin
        start_q[i] <= '0;
        end_q[i]   <= '0;
      end
    end else begin
      trig_q <= trig_i;
      if (run_q) begin
        cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        if (rec_w)                idle_q <= '0;
        else if (idle_q < IDLE_LIM) idle_q <= idle_q + 1'b1;
      end
      if (rec_w) begin
        start_q[idx_q] <= cnt_q;
        if (idx_q != '0) begin
          end_q[prev_w] <= cnt_q;
          val_q[prev_w] <= 1'b1;
        end
        idx_q <= idx_q + 1'b1;
      end
      if (ovf_w) ovf_q <= 1'b1;
      if (fin_w) begin
        run_q <= 1'b0;
        fin_q <= 1'b1;
        tmo_q <= tmo_w;
        if (open_w) begin
          end_q[prev_w] <= cnt_q;
          val_q[prev_w] <= 1'b1;
        end
      end
    end
  end

  wire             rd_in_w  = rd_idx_i < LAST;
  wire [IDX_W-1:0] rd_sel_w = rd_in_w ? rd_idx_i : '0;

  assign rd_valid_o    = rd_in_w && val_q[rd_sel_w];
  assign rd_start_o    = rd_valid_o ? start_q[rd_sel_w] : '0;
  assign rd_end_o      = rd_valid_o ? end_q[rd_sel_w]   : '0;
  assign busy_o        = run_q;
  assign finished_o    = fin_q;
  assign timed_out_o   = tmo_q;
  assign overflow_o    = ovf_q;
  assign stage_count_o = idx_q;
endmodule

// File: rtl/stage_window_profiler_chk.sv
module stage_window_profiler_chk #(
  parameter int NUM_STAGES = 5,
  parameter int CNT_W      = 32,
  parameter int IDX_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [IDX_W-1:0] idx,
  input logic             fin,
  input logic             tmo,
  input logic             ovf,
  input logic             rd_valid,
  input logic [CNT_W-1:0] rd_start,
  input logic [CNT_W-1:0] rd_end
);
  AST_IDLE_EMPTY:  assert property (@(posedge clk) disable iff (!rst_n) (!run && !fin) |-> (idx == '0)); // R1
  AST_ARM_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) arm |=> (run && idx == '0 && !fin && !ovf && !tmo)); // R2
  AST_RANGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> (rd_end >= rd_start)); // R3
  AST_TMO_FIN:     assert property (@(posedge clk) disable iff (!rst_n) tmo |-> fin); // R5
  AST_IDX_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) idx <= IDX_W'(NUM_STAGES)); // R6
  AST_OVF_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) (ovf && !arm) |=> ovf); // R6
  AST_CNT_STEP:    assert property (@(posedge clk) disable iff (!rst_n) (run && !arm) |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) && cnt == '1))); // R7
  AST_FIN_FROZEN:  assert property (@(posedge clk) disable iff (!rst_n) (fin && !arm) |=> ($stable(cnt) && $stable(idx) && fin)); // R9
endmodule

bind stage_window_profiler stage_window_profiler_chk #(
  .NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm_i), .run(run_q), .cnt(cnt_q), .idx(idx_q),
  .fin(fin_q), .tmo(tmo_q), .ovf(ovf_q), .rd_valid(rd_valid_o),
  .rd_start(rd_start_o), .rd_end(rd_end_o)
);

// File: tb/test_stage_window_profiler.sv
module test_stage_window_profiler;
  localparam int NS   = 5;
  localparam int CW   = 12;
  localparam int TO   = 50;
  localparam int IW   = $clog2(NS + 1);
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, trig = 1'b0, done = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic rd_valid, busy, fin, tmo, ovf;
  logic [CW-1:0] rd_start, rd_end;
  logic [IW-1:0] cnt;

  int tests = 0, fails = 0, e = 0;

  always #4 clk = ~clk;

  stage_window_profiler #(.NUM_STAGES(NS), .CNT_W(CW), .TIMEOUT_CYC(TO)) i_stage_window_profiler (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .trig_i(trig), .done_i(done),
    .rd_idx_i(rd_idx), .rd_valid_o(rd_valid), .rd_start_o(rd_start), .rd_end_o(rd_end),
    .busy_o(busy), .finished_o(fin), .timed_out_o(tmo), .overflow_o(ovf),
    .stage_count_o(cnt)
  );

  task automatic chk(string r, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    e++;
  endtask

  task automatic wait_t(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic do_arm();
    arm = 1'b1;
    tick();
    arm = 1'b0;
    e = 0;
  endtask

  task automatic toggle(output int st);
    trig = ~trig;
    st = e;
    tick();
  endtask

  task automatic pulse_done(output int st);
    done = 1'b1;
    st = e;
    tick();
    done = 1'b0;
  endtask

  task automatic chk_stage(string r, int i, bit v, int s, int en);
    rd_idx = IW'(i);
    #1;
    chk(r, $sformatf("stage %0d valid", i), rd_valid, v);
    chk(r, $sformatf("stage %0d start", i), rd_start, s);
    chk(r, $sformatf("stage %0d end", i), rd_end, en);
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "finished", fin, 0);
    chk("R1", "timed_out", tmo, 0);
    chk("R1", "overflow", ovf, 0);
    chk("R1", "count", cnt, 0);
    chk_stage("R1", 0, 0, 0, 0);
  endtask

  task automatic t_basic();
    int s[NS+1];
    do_arm();
    chk("R2", "busy after arm", busy, 1);
    wait_t(3);
    toggle(s[0]);
    chk("R2", "first stamp", s[0], 3);
    wait_t(7);
    toggle(s[1]);
    chk("R3", "count after 2", cnt, 2);
    chk_stage("R3", 0, 1, s[0], s[1]);
    chk_stage("R8", 1, 0, 0, 0);
    wait_t(2);  toggle(s[2]);
    wait_t(10); toggle(s[3]);
    toggle(s[4]);
    chk_stage("R8", 4, 0, 0, 0);
    wait_t(4);
    pulse_done(s[5]);
    chk("R4", "finished", fin, 1);
    chk("R4", "timed_out", tmo, 0);
    chk("R4", "busy", busy, 0);
    chk("R3", "count", cnt, 5);
    for (int i = 0; i < NS; i++) chk_stage("R3", i, 1, s[i], s[i+1]);
    for (int i = NS; i < 8; i++) chk_stage("R8", i, 0, 0, 0);
  endtask

  task automatic t_after_fin();
    int x;
    toggle(x);
    wait_t(2);
    pulse_done(x);
    toggle(x);
    chk("R9", "count", cnt, 5);
    chk("R9", "overflow", ovf, 0);
    chk("R9", "finished", fin, 1);
    chk_stage("R9", 0, 1, 3, 11);
  endtask

  task automatic t_rearm();
    do_arm();
    chk("R2", "count cleared", cnt, 0);
    chk("R2", "finished cleared", fin, 0);
    chk_stage("R2", 0, 0, 0, 0);
    chk_stage("R2", 4, 0, 0, 0);
  endtask

  task automatic t_timeout();
    int s0, s1;
    do_arm();
    toggle(s0);
    wait_t(5);
    toggle(s1);
    wait_t(TO + 5);
    chk("R5", "finished", fin, 1);
    chk("R5", "timed_out", tmo, 1);
    chk("R5", "count", cnt, 2);
    chk_stage("R5", 0, 1, s0, s1);
    chk_stage("R5", 1, 1, s1, s1 + TO + 1);
  endtask

  task automatic t_overflow();
    int s[NS+1];
    int x;
    do_arm();
    for (int i = 0; i < NS; i++) begin
      toggle(s[i]);
      wait_t(2);
    end
    toggle(x);
    chk("R6", "overflow", ovf, 1);
    chk("R6", "count", cnt, NS);
    chk_stage("R6", 4, 0, 0, 0);
    wait_t(2);
    pulse_done(s[NS]);
    chk("R6", "overflow held", ovf, 1);
    chk_stage("R6", 4, 1, s[4], s[NS]);
  endtask

  task automatic t_sat();
    int s0, s1, d;
    do_arm();
    wait_t(CMAX - 5);
    toggle(s0);
    wait_t(2);
    toggle(s1);
    wait_t(10);
    pulse_done(d);
    chk_stage("R7", 0, 1, s0, s1);
    chk_stage("R7", 1, 1, s1, CMAX);
  endtask

  task automatic t_coincide();
    int s0, d;
    do_arm();
    toggle(s0);
    wait_t(3);
    trig = ~trig;
    pulse_done(d);
    chk("R10", "count", cnt, 1);
    chk("R10", "overflow", ovf, 0);
    chk("R10", "timed_out", tmo, 0);
    chk_stage("R10", 0, 1, s0, d);
  endtask

  task automatic t_done_empty();
    int d;
    do_arm();
    wait_t(3);
    pulse_done(d);
    chk("R4", "finished empty", fin, 1);
    chk("R4", "count empty", cnt, 0);
    chk_stage("R4", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_after_fin();
    t_rearm();
    t_timeout();
    t_overflow();
    t_coincide();
    t_done_empty();
    t_sat();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule